// File: doc/BRIEF.md
# Cache Control Register and Tag Invalidation Sequencer

This block holds the control word of a small tag array cache and owns the one write port that clears tag valid bits. Software writes an 8-bit control word. Seven of its bits are kept and read back. The eighth bit is a strobe that asks for a tag invalidation.

An invalidation walks through the tag array. It spends a fixed number of preparation cycles, then clears one entry per cycle in ascending index order. The walk covers all 128 entries, one 64-entry half, or nothing, depending on the cache-split and half-select bits that apply when the walk starts.

The same block gates the cache array. The array is live only when the cache is enabled and no walk is running. The block also decides two things:
- whether a line-fill buffer may be written into a tag location while the freeze bit is set;
- whether a privileged push command clears the single entry selected by its address.

Top module: `cache_ctl_seq`

## Requirements
- R1: After a synchronous active-low reset, every stored control bit reads as 0, `busy` and `walk_done` are low, `array_active` is low and no tag clear is driven.
- R2: A write with `cfg_wr` high updates the stored bits on the next clock edge. The bit layout is: bit0 cache enable, bit1 instruction caching off, bit2 data caching off, bit3 invalidate upper half, bit4 invalidate lower half, bit5 freeze, bit6 push-invalidate off, bit7 invalidate strobe. `cfg_rdata` returns bits 6..0 as stored, and bit7 always reads as 0.
- R3: A write with bit7 set while no walk runs starts a walk whatever the enable bit holds. `busy` is high from the next cycle. After OVERHEAD preparation cycles, `tag_clr_we` is high for one entry per cycle with `tag_clr_idx` counting up by one.
- R4: The walk clears all 128 entries (0 to 127) in two cases: both caching-off bits are clear and neither half bit is set, or exactly one caching-off bit is set.
- R5: With both caching-off bits clear, bit3 alone clears entries 64 to 127, and bit4 alone clears entries 0 to 63.
- R6: No walk starts, and neither `busy` nor `walk_done` rises, in two cases: both caching-off bits are set, or both caching-off bits are clear and both half bits are set.
- R7: `busy` stays high for exactly OVERHEAD plus the number of cleared entries cycles. `walk_done` is high for one cycle, in the first cycle `busy` is low again.
- R8: A write during a walk updates the stored bits at once and does not disturb the running walk. If that write carries bit7, one new walk starts on the edge after `walk_done`, with coverage taken from the bits stored then.
- R9: `array_active` equals the enable bit while no walk runs, and is low during a walk.
- R10: `fill_grant` is high when `fill_req` is high, the array is active, and either freeze is clear or `fill_line_valid` reports the target location invalid. A valid entry is never granted while freeze is set.
- R11: With no walk running and push-invalidate off clear, `push_req` drives `tag_clr_we` in the same cycle with `tag_clr_idx` equal to `push_addr[10:4]`. With push-invalidate off set, a push drives no clear. During a walk the walker alone drives the clear port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 8 | Control word write value |
| cfg_rdata | output | 8 | Stored control bits, bit7 reads 0 |
| fill_req | input | 1 | Line-fill buffer asks to write its tag location |
| fill_line_valid | input | 1 | Current valid bit of the fill's target location |
| fill_grant | output | 1 | Fill may write the tag location |
| push_req | input | 1 | Privileged push command present |
| push_addr | input | 32 | Push address; bits 10..4 select the entry |
| tag_clr_we | output | 1 | Clear the valid bit at `tag_clr_idx` |
| tag_clr_idx | output | 7 | Tag entry to clear |
| busy | output | 1 | Invalidation walk in progress |
| walk_done | output | 1 | One-cycle pulse when a walk ends |
| array_active | output | 1 | Cache array may serve accesses |

## Verification
The assertions assume several things about the inputs:
- `fill_line_valid` is meaningful only while `fill_req` is high;
- `push_req` is a single-cycle strobe;
- reset is held for at least one clock edge before any write.

The stimulus drives every input on the falling edge and holds it for a full cycle. It lowers `push_req` and `fill_req` after each probe. It issues control writes as single-cycle strobes, including writes that land mid-walk and on the cycle a walk ends.

// File: rtl/cctl_pkg.sv
// Package: shared types for the cache control sequencer.
// Assumes a 7-bit stored control word with the enable bit at position 0.
package cctl_pkg;

    localparam int CTRL_W  = 8;
    localparam int STORE_W = 7;
    localparam int INV_BIT = 7;

    // Stored control bits; the first member is the most significant bit.
    typedef struct packed {
        logic push_off;  // bit6
        logic freeze;    // bit5
        logic inv_lo;    // bit4
        logic inv_hi;    // bit3
        logic d_off;     // bit2
        logic i_off;     // bit1
        logic enable;    // bit0
    } cctl_cfg_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_PREP  = 2'd1,
        W_CLEAR = 2'd2
    } walk_st_t;

endpackage

// File: rtl/cctl_regs.sv
// Module: control word storage.
// Keeps seven control bits. Turns bit7 of a write into a one-cycle
// invalidation request. Presents the value the word takes after this
// cycle's write, so a walk started by the write uses the new bits.
// Assumes cfg_wr is a single-cycle strobe per write.
module cctl_regs
    import cctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CTRL_W-1:0] cfg_wdata,
    output cctl_cfg_t         cfg_q,
    output cctl_cfg_t         cfg_next,
    output logic              inv_req,
    output logic [CTRL_W-1:0] cfg_rdata
);

    // Value the stored word holds after this cycle's edge.
    always_comb begin
        cfg_next = cfg_q;
        if (cfg_wr) cfg_next = cctl_cfg_t'(cfg_wdata[STORE_W-1:0]);
    end

    // Invalidation request: the strobe bit of a write.
    assign inv_req = cfg_wr & cfg_wdata[INV_BIT];

    // Stored control bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_next;
    end

    // Readback: the strobe bit is never stored.
    assign cfg_rdata = {1'b0, cfg_q};

    // R2
    store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata[STORE_W-1:0] == $past(cfg_wdata[STORE_W-1:0]));

endmodule

// File: rtl/cctl_walker.sv
// Module: tag invalidation walk sequencer.
// Chooses the coverage from the control bits that apply at the start.
// Spends OVERHEAD preparation cycles, then clears one entry per cycle.
// A request that arrives during a walk is held and started once the walk ends.
// Assumes OVERHEAD >= 1 and an even entry count.
module cctl_walker
    import cctl_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int OVERHEAD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_req,
    input  cctl_cfg_t        cfg_sel,
    output logic             busy,
    output logic             walk_done,
    output logic             walk_we,
    output logic [IDX_W-1:0] walk_idx
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int HALF    = ENTRIES / 2;
    localparam int PC_W    = $clog2(OVERHEAD) + 1;
    localparam logic [PC_W-1:0]  PREP_LAST = PC_W'(OVERHEAD - 1);
    localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(ENTRIES - 1);
    localparam logic [IDX_W-1:0] IDX_HALF  = IDX_W'(HALF);
    localparam logic [IDX_W-1:0] IDX_HLAST = IDX_W'(HALF - 1);

    walk_st_t         st;
    logic [PC_W-1:0]  prep_cnt;
    logic [IDX_W-1:0] last_q;
    logic             pend;
    logic             cov_none;
    logic [IDX_W-1:0] cov_base;
    logic [IDX_W-1:0] cov_last;

    // Coverage choice: split cache, unified cache, or fully disabled.
    always_comb begin
        cov_none = 1'b0;
        cov_base = '0;
        cov_last = IDX_TOP;
        if (cfg_sel.i_off && cfg_sel.d_off) begin
            cov_none = 1'b1;
        end else if (!cfg_sel.i_off && !cfg_sel.d_off) begin
            unique case ({cfg_sel.inv_hi, cfg_sel.inv_lo})
                2'b10:   cov_base = IDX_HALF;
                2'b01:   cov_last = IDX_HLAST;
                2'b11:   cov_none = 1'b1;
                default: ;
            endcase
        end
    end

    // Walk state machine with a held restart request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= W_IDLE;
            prep_cnt  <= '0;
            walk_idx  <= '0;
            last_q    <= '0;
            pend      <= 1'b0;
            walk_done <= 1'b0;
        end else begin
            walk_done <= 1'b0;
            unique case (st)
                W_IDLE: begin
                    if (inv_req || pend) begin
                        pend <= 1'b0;
                        if (!cov_none) begin
                            st       <= W_PREP;
                            prep_cnt <= '0;
                            walk_idx <= cov_base;
                            last_q   <= cov_last;
                        end
                    end
                end
                W_PREP: begin
                    if (prep_cnt == PREP_LAST) st <= W_CLEAR;
                    else                       prep_cnt <= prep_cnt + 1'b1;
                end
                W_CLEAR: begin
                    if (walk_idx == last_q) begin
                        st        <= W_IDLE;
                        walk_done <= 1'b1;
                    end else begin
                        walk_idx <= walk_idx + 1'b1;
                    end
                end
                default: st <= W_IDLE;
            endcase
            if (st != W_IDLE && inv_req) pend <= 1'b1;
        end
    end

    // Outputs derived from the state.
    assign busy    = (st != W_IDLE);
    assign walk_we = (st == W_CLEAR);

    // R3
    clear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_we && $past(walk_we) |-> walk_idx == $past(walk_idx) + 1'b1);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);

    // R7
    done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> !busy && $past(busy));

    // R3
    clear_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_we |-> busy);

endmodule

// File: rtl/cctl_access.sv
// Module: tag clear port arbitration, fill gating and array gating.
// The walker owns the clear port while busy. Otherwise a push command
// may clear the entry named by its address. Fills are gated by freeze.
// Assumes push_req is a single-cycle strobe.
module cctl_access
    import cctl_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int ADDR_W   = 32,
    parameter int PUSH_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cctl_cfg_t         cfg_q,
    input  logic              busy,
    input  logic              walk_we,
    input  logic [IDX_W-1:0]  walk_idx,
    input  logic              fill_req,
    input  logic              fill_line_valid,
    input  logic              push_req,
    input  logic [ADDR_W-1:0] push_addr,
    output logic              fill_grant,
    output logic              array_active,
    output logic              tag_clr_we,
    output logic [IDX_W-1:0]  tag_clr_idx
);

    localparam int PUSH_MSB = PUSH_LSB + IDX_W - 1;

    logic             push_hit;
    logic [IDX_W-1:0] push_idx;
    logic             unused_addr_bits;

    // Entry selected by the push address.
    assign push_idx         = push_addr[PUSH_MSB:PUSH_LSB];
    assign unused_addr_bits = ^{push_addr[ADDR_W-1:PUSH_MSB+1], push_addr[PUSH_LSB-1:0]};

    // Array gating: enabled and not walking.
    assign array_active = cfg_q.enable & ~busy;

    // Fill gating: a frozen array only accepts fills into invalid locations.
    assign fill_grant = fill_req & array_active & (~cfg_q.freeze | ~fill_line_valid);

    // Push invalidation, honoured only outside a walk.
    assign push_hit = push_req & ~cfg_q.push_off & ~busy;

    // Clear port mux: the walker first, then a push.
    always_comb begin
        tag_clr_we  = walk_we | push_hit;
        tag_clr_idx = walk_we ? walk_idx : push_idx;
    end

    // R10
    fill_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_grant |-> !(cfg_q.freeze && fill_line_valid));

    // R9
    active_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        array_active |-> !busy);

    // R11
    push_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && cfg_q.push_off && !busy |-> !tag_clr_we);

    // R11
    walk_owns_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_we |-> tag_clr_idx == walk_idx);

endmodule

// File: rtl/cache_ctl_seq.sv
// Module: cache control register with tag invalidation sequencer (top).
// Connects the control storage, the walk sequencer and the access gating.
// Assumes one write port for control and one clear port into the tag array.
module cache_ctl_seq
    import cctl_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int OVERHEAD = 2,
    parameter int ADDR_W   = 32,
    parameter int PUSH_LSB = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              fill_req,
    input  logic              fill_line_valid,
    output logic              fill_grant,
    input  logic              push_req,
    input  logic [ADDR_W-1:0] push_addr,
    output logic              tag_clr_we,
    output logic [IDX_W-1:0]  tag_clr_idx,
    output logic              busy,
    output logic              walk_done,
    output logic              array_active
);

    cctl_cfg_t        cfg_q;
    cctl_cfg_t        cfg_next;
    logic             inv_req;
    logic             walk_we;
    logic [IDX_W-1:0] walk_idx;

    cctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .cfg_next  (cfg_next),
        .inv_req   (inv_req),
        .cfg_rdata (cfg_rdata)
    );

    cctl_walker #(.IDX_W(IDX_W), .OVERHEAD(OVERHEAD)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .inv_req   (inv_req),
        .cfg_sel   (cfg_next),
        .busy      (busy),
        .walk_done (walk_done),
        .walk_we   (walk_we),
        .walk_idx  (walk_idx)
    );

    cctl_access #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .PUSH_LSB(PUSH_LSB)) u_acc (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_q           (cfg_q),
        .busy            (busy),
        .walk_we         (walk_we),
        .walk_idx        (walk_idx),
        .fill_req        (fill_req),
        .fill_line_valid (fill_line_valid),
        .push_req        (push_req),
        .push_addr       (push_addr),
        .fill_grant      (fill_grant),
        .array_active    (array_active),
        .tag_clr_we      (tag_clr_we),
        .tag_clr_idx     (tag_clr_idx)
    );

endmodule

// File: tb/sim_cache_ctl_seq.sv
// Bench: behavioural reference model compared on every clock, plus scenario checks.
module sim_cache_ctl_seq;

    localparam int OH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        fill_req = 1'b0;
    logic        fill_line_valid = 1'b0;
    logic        fill_grant;
    logic        push_req = 1'b0;
    logic [31:0] push_addr = '0;
    logic        tag_clr_we;
    logic [6:0]  tag_clr_idx;
    logic        busy;
    logic        walk_done;
    logic        array_active;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // Reference model state.
    logic [6:0] m_cfg = '0;
    int m_st = 0, m_cnt = 0, m_idx = 0, m_last = 0;
    bit m_pend = 0, m_done = 0;

    // Per-walk statistics observed at the ports.
    int n_clr, n_busy, first_idx, last_idx;
    bit seen_done;

    always #10 clk = ~clk;

    cache_ctl_seq #(.OVERHEAD(OH)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .fill_req(fill_req), .fill_line_valid(fill_line_valid),
        .fill_grant(fill_grant), .push_req(push_req), .push_addr(push_addr),
        .tag_clr_we(tag_clr_we), .tag_clr_idx(tag_clr_idx), .busy(busy),
        .walk_done(walk_done), .array_active(array_active)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Coverage per the requirements: returns entry count, base via output.
    function automatic int coverage(input logic [6:0] c, output int b);
        b = 0;
        if (c[1] && c[2]) return 0;
        if (c[1] || c[2]) return 128;
        if (c[3] && c[4]) return 0;
        if (c[3]) begin b = 64; return 64; end
        if (c[4]) return 64;
        return 128;
    endfunction

    task automatic model_step();
        int b, n, old_st;
        logic [6:0] sel;
        bit trig;
        if (!rst_n) begin
            m_cfg = '0; m_st = 0; m_cnt = 0; m_idx = 0; m_last = 0;
            m_pend = 0; m_done = 0;
            return;
        end
        trig   = cfg_wr && cfg_wdata[7];
        sel    = cfg_wr ? cfg_wdata[6:0] : m_cfg;
        old_st = m_st;
        m_done = 0;
        if (m_st == 0) begin
            if (trig || m_pend) begin
                m_pend = 0;
                n = coverage(sel, b);
                if (n > 0) begin m_st = 1; m_cnt = 0; m_idx = b; m_last = b + n - 1; end
            end
        end else if (m_st == 1) begin
            if (m_cnt == OH - 1) m_st = 2; else m_cnt++;
        end else begin
            if (m_idx == m_last) begin m_st = 0; m_done = 1; end else m_idx++;
        end
        if (old_st != 0 && trig) m_pend = 1;
        if (cfg_wr) m_cfg = cfg_wdata[6:0];
    endtask

    task automatic compare();
        bit mb, wwe, exp_we, exp_act;
        int exp_idx;
        if (!rst_n) return;
        mb      = (m_st != 0);
        wwe     = (m_st == 2);
        exp_we  = wwe || (push_req && !m_cfg[6] && !mb);
        exp_idx = wwe ? m_idx : int'(push_addr[10:4]);
        exp_act = m_cfg[0] && !mb;
        check("R3 busy", int'(busy), int'(mb));
        check("R7 walk_done", int'(walk_done), int'(m_done));
        check("R11 tag_clr_we", int'(tag_clr_we), int'(exp_we));
        if (exp_we) check("R4 tag_clr_idx", int'(tag_clr_idx), exp_idx);
        check("R9 array_active", int'(array_active), int'(exp_act));
        check("R10 fill_grant", int'(fill_grant),
              int'(fill_req && exp_act && (!m_cfg[5] || !fill_line_valid)));
        check("R2 cfg_rdata", int'(cfg_rdata), int'({1'b0, m_cfg}));
    endtask

    // One clock: compare after the falling-edge drive, step model at the rising edge.
    task automatic cyc();
        #2;
        compare();
        if (rst_n) begin
            if (tag_clr_we && busy) begin
                if (n_clr == 0) first_idx = int'(tag_clr_idx);
                last_idx = int'(tag_clr_idx);
                n_clr++;
            end
            if (busy) n_busy++;
            if (walk_done) seen_done = 1;
        end
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic clr_stats();
        n_clr = 0; n_busy = 0; first_idx = -1; last_idx = -1; seen_done = 0;
    endtask

    task automatic write(input logic [7:0] d);
        cfg_wr = 1'b1; cfg_wdata = d;
        cyc();
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic wait_done(input int maxc);
        for (int k = 0; k < maxc && !seen_done; k++) cyc();
    endtask

    task automatic run_walk(input logic [7:0] d, input int exp_n, input int exp_base,
                            input string tag);
        clr_stats();
        write(d);
        wait_done(exp_n == 0 ? 8 : 400);
        check({tag, " clear count"}, n_clr, exp_n);
        check("R7 busy length", n_busy, exp_n == 0 ? 0 : OH + exp_n);
        check("R7 done seen", int'(seen_done), exp_n == 0 ? 0 : 1);
        if (exp_n > 0) begin
            check({tag, " first index"}, first_idx, exp_base);
            check({tag, " last index"}, last_idx, exp_base + exp_n - 1);
        end
        cyc();
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < 3; i++) cyc();
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        check("R1 rdata", int'(cfg_rdata), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 active", int'(array_active), 0);
        check("R1 clear", int'(tag_clr_we), 0);

        // R2 store and readback, strobe bit reads 0
        write(8'h65);
        check("R2 readback", int'(cfg_rdata), 8'h65);
        write(8'h00);

        // R3 R4 walk runs with enable clear, full coverage
        run_walk(8'h80, 128, 0, "R4 split none-half");
        run_walk(8'h82, 128, 0, "R4 unified instr-off");
        run_walk(8'h84, 128, 0, "R4 unified data-off");
        // R5 half walks
        run_walk(8'h88, 64, 64, "R5 upper");
        run_walk(8'h91, 64, 0, "R5 lower");
        // R6 no walk
        run_walk(8'h98, 0, 0, "R6 both halves");
        run_walk(8'h86, 0, 0, "R6 both off");

        // R8 write mid-walk: stored at once, new walk after done
        clr_stats();
        write(8'h80);
        for (int k = 0; k < 10; k++) cyc();
        write(8'h91);
        check("R8 rdata mid-walk", int'(cfg_rdata), 8'h11);
        check("R8 still busy", int'(busy), 1);
        wait_done(400);
        check("R8 first walk count", n_clr, 128);
        clr_stats();
        cyc();
        wait_done(400);
        check("R8 second walk count", n_clr, 64);
        check("R8 second walk base", first_idx, 0);
        cyc();

        // R10 fill gating
        write(8'h21);
        fill_req = 1'b1; fill_line_valid = 1'b1; #1;
        check("R10 frozen valid", int'(fill_grant), 0);
        cyc();
        fill_line_valid = 1'b0; #1;
        check("R10 frozen invalid", int'(fill_grant), 1);
        cyc();
        fill_req = 1'b0;
        write(8'h01);
        fill_req = 1'b1; fill_line_valid = 1'b1; #1;
        check("R10 unfrozen valid", int'(fill_grant), 1);
        cyc();
        fill_req = 1'b0;
        write(8'h00);
        fill_req = 1'b1; #1;
        check("R10 disabled", int'(fill_grant), 0);
        cyc();
        fill_req = 1'b0; fill_line_valid = 1'b0;

        // R11 push invalidation
        push_req = 1'b1; push_addr = 32'h0000_05A0; #1;
        check("R11 push we", int'(tag_clr_we), 1);
        check("R11 push idx", int'(tag_clr_idx), 8'h5A);
        cyc();
        push_req = 1'b0;
        write(8'h40);
        push_req = 1'b1; push_addr = 32'h0000_07F0; #1;
        check("R11 push disabled", int'(tag_clr_we), 0);
        cyc();
        push_req = 1'b0;
        write(8'h88);
        cyc(); cyc(); cyc(); cyc();
        push_req = 1'b1; push_addr = 32'h0000_0010; #1;
        check("R11 walk owns port idx", int'(tag_clr_idx) >= 64, 1);
        cyc();
        push_req = 1'b0;
        clr_stats();
        wait_done(200);
        cyc(); cyc();

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule